// File: doc/BRIEF.md
# Receive descriptor ring engine

This block is the device side of one receive ring kept in host memory. Software writes four values through a small register port: a configuration word, the base of the descriptor ring, the base of an 8-byte status area, and a write index. The write index marks how far software has handed descriptors to the device. The engine reads the next free descriptor, which is one 32-bit word holding a 256-byte-aligned buffer address. It then streams incoming frame bytes into that buffer, one byte per host write.

A buffer is closed in two cases: when it reaches its configured size, or when no byte has arrived for a programmable idle time counted on a microsecond tick. On close, the engine writes the index of the filled descriptor to the status area and can pulse an interrupt. It then moves on to the next descriptor.

The channel mode field selects normal running, stopping at once, or stopping at the next frame boundary. A status bit shows when the channel has gone quiet. When no descriptor is free, the byte stream is held off with a ready signal.

Top module: `rx_ring_engine`

## Requirements
- R1: After reset, in_ready and irq are 0, no memory access is issued, and stat_o reads 0x0100_0000 (bit 24 idle set, last index 0).
- R2: While the channel runs and a descriptor is free, the engine issues one read at (ring base << 8) + 4 * index. mem_rdata must be valid from the clock edge that sees mem_rd. Bits 27:0 of that word become buffer address bits 35:8; bits 31:28 are ignored.
- R3: Each accepted byte is written to buffer address + fill offset. mem_be is one-hot at lane address[1:0], and the byte is replicated on all four lanes of mem_wdata.
- R4: A buffer closes once it holds (cfg[17:16] + 1) * 4096 bytes. Later bytes of the same frame go to the next descriptor.
- R5: A partly filled buffer closes after cfg[11:4] * 32 us_tick pulses with no accepted byte. Every accepted byte restarts the count, and a value of 0 disables the timeout.
- R6: A close is one full-word write (mem_be = 0xF) at (status base << 4). Data bits 11:0 carry the index of the descriptor just filled and all other bits are 0. stat_o[11:0] then shows the same index.
- R7: irq pulses for one cycle together with the close write when cfg[13:12] = 01. For any other value of that field there is no pulse.
- R8: A descriptor is free while the read index differs from the write index, taken with its low 3 bits cleared and reduced modulo the ring size. While none is free, in_ready stays 0.
- R9: Mode cfg[31:30] = 00 (or 11) drops in_ready at once. A partly filled buffer is closed and reported; a fetched but empty buffer is given back without advancing the index. Once stopped, stat_o[24] = 1.
- R10: Mode 01 keeps accepting the frame in progress through its in_last byte, then closes the buffer, sets stat_o[24] and refuses a new frame. Mode 10 is normal operation.
- R11: The ring holds 2^cfg[23:20] entries, with values below 5 acting as 5 and values above 12 acting as 12. The read index wraps to 0 after the last entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 config, 1 ring base, 2 status base, 3 write index |
| reg_wdata | input | 32 | Register write data |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| in_valid | input | 1 | Frame byte valid |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Byte is the last of its frame |
| in_ready | output | 1 | Engine accepts the byte this cycle |
| mem_rd | output | 1 | Descriptor read request |
| mem_wr | output | 1 | Host memory write |
| mem_addr | output | 36 | Host byte address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Descriptor read data |
| irq | output | 1 | Close interrupt pulse |
| stat_o | output | 32 | Bit 24 idle, bits 11:0 last filled index |

## Verification
Two events can fall into the same cycle. The first is a byte arriving just as the idle timer would run out. The bench spaces bytes by gaps just short of the timeout and checks that the buffer stays open, so the byte wins and the count restarts. The second is a stop request that lands while a frame is still streaming. The bench switches to the frame-boundary mode mid-frame and judges that every remaining byte of that frame is written to memory, and that exactly one close follows with the idle bit set. A stop in the immediate mode with an empty fetched buffer is judged by the next close reusing the same descriptor index.

// File: rtl/rx_ring_engine.sv
module rx_ring_engine #(
  parameter int IDXW = 12,
  parameter int AW   = 36,
  parameter int CNTW = 15,
  parameter int TMOW = 13
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [1:0]      reg_sel,
  input  logic [31:0]     reg_wdata,
  input  logic            us_tick,
  input  logic            in_valid,
  input  logic [7:0]      in_data,
  input  logic            in_last,
  output logic            in_ready,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [AW-1:0]   mem_addr,
  output logic [3:0]      mem_be,
  output logic [31:0]     mem_wdata,
  input  logic [31:0]     mem_rdata,
  output logic            irq,
  output logic [31:0]     stat_o
);

  localparam int SPANW = IDXW + 1;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_LOAD, S_FILL, S_CLOSE} st_t;

  st_t             st;
  logic [31:0]     cfg;
  logic [27:0]     ring_base;
  logic [31:0]     stat_base;
  logic [IDXW-1:0] wr_idx, rd_idx, last_idx;
  logic [AW-1:0]   buf_addr;
  logic [CNTW-1:0] fill_cnt;
  logic [TMOW-1:0] tmo_cnt;
  logic            in_frame;

  logic [1:0]      mode;
  logic [3:0]      lg;
  logic [IDXW-1:0] ring_mask, wr_eff;
  logic [CNTW-1:0] buf_last;
  logic [TMOW-1:0] tmo_lim;
  logic            run, has_free, tmo_hit, accept, idle;
  logic            unused_bits;

  assign mode      = cfg[31:30];
  assign lg        = (cfg[23:20] < 4'd5) ? 4'd5 : ((cfg[23:20] > 4'd12) ? 4'd12 : cfg[23:20]);
  assign ring_mask = IDXW'((SPANW'(1) << lg) - SPANW'(1));
  assign wr_eff    = wr_idx & ring_mask & ~IDXW'(7);
  assign has_free  = (rd_idx != wr_eff);
  assign run       = (mode == 2'b10) || ((mode == 2'b01) && in_frame);
  assign buf_last  = CNTW'({cfg[17:16], 12'hFFF});
  assign tmo_lim   = TMOW'({cfg[11:4], 5'd0});
  assign tmo_hit   = (tmo_lim != '0) && (tmo_cnt >= tmo_lim) && (fill_cnt != '0);
  assign in_ready  = (st == S_FILL) && run;
  assign accept    = in_valid && in_ready;
  assign idle      = (st == S_IDLE) && !run;
  assign stat_o    = {7'd0, idle, 24'(last_idx)};
  assign unused_bits = ^{cfg[29:24], cfg[19:18], cfg[15:14], cfg[3:0], mem_rdata[31:28]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg       <= '0;
      ring_base <= '0;
      stat_base <= '0;
      wr_idx    <= '0;
    end else if (reg_wr) begin
      case (reg_sel)
        2'd0: cfg       <= reg_wdata;
        2'd1: ring_base <= reg_wdata[27:0];
        2'd2: stat_base <= reg_wdata;
        default: wr_idx <= reg_wdata[IDXW-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      rd_idx    <= '0;
      last_idx  <= '0;
      buf_addr  <= '0;
      fill_cnt  <= '0;
      tmo_cnt   <= '0;
      in_frame  <= 1'b0;
      mem_rd    <= 1'b0;
      mem_wr    <= 1'b0;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
      irq       <= 1'b0;
    end else begin
      mem_rd <= 1'b0;
      mem_wr <= 1'b0;
      irq    <= 1'b0;

      if (mode == 2'b00 || mode == 2'b11) in_frame <= 1'b0;
      else if (accept)                    in_frame <= !in_last;

      if (accept)                          tmo_cnt <= '0;
      else if (us_tick && tmo_cnt != '1)   tmo_cnt <= tmo_cnt + TMOW'(1);

      case (st)
        S_IDLE: if (run && has_free) begin
          mem_rd   <= 1'b1;
          mem_addr <= AW'({ring_base, 8'h00}) + AW'({rd_idx, 2'b00});
          st       <= S_REQ;
        end
        S_REQ: st <= S_LOAD;
        S_LOAD: begin
          buf_addr <= AW'({mem_rdata[27:0], 8'h00});
          fill_cnt <= '0;
          tmo_cnt  <= '0;
          st       <= S_FILL;
        end
        S_FILL: begin
          if (accept) begin
            mem_wr    <= 1'b1;
            mem_addr  <= buf_addr + AW'(fill_cnt);
            mem_be    <= 4'b0001 << fill_cnt[1:0];
            mem_wdata <= {4{in_data}};
            fill_cnt  <= fill_cnt + CNTW'(1);
            if (fill_cnt == buf_last) st <= S_CLOSE;
          end else if (!run) begin
            st <= (fill_cnt != '0) ? S_CLOSE : S_IDLE;
          end else if (tmo_hit) begin
            st <= S_CLOSE;
          end
        end
        S_CLOSE: begin
          mem_wr    <= 1'b1;
          mem_addr  <= AW'({stat_base, 4'h0});
          mem_be    <= 4'hF;
          mem_wdata <= 32'(rd_idx);
          last_idx  <= rd_idx;
          rd_idx    <= (rd_idx + IDXW'(1)) & ring_mask;
          irq       <= (cfg[13:12] == 2'b01);
          fill_cnt  <= '0;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rx_ring_engine_chk.sv
module rx_ring_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [3:0]  mem_be,
  input logic [31:0] mem_wdata,
  input logic        irq,
  input logic [31:0] stat_o
);

  p_one_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  p_fetch_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);

  p_byte_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mem_be != 4'hF) |-> $countones(mem_be) == 1);

  p_status_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && mem_be == 4'hF) |-> mem_wdata[31:12] == 20'd0);

  p_irq_with_report_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mem_wr && mem_be == 4'hF));

  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_o[24] |-> (!in_ready && !mem_rd));

endmodule

bind rx_ring_engine rx_ring_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .mem_rd(mem_rd),
  .mem_wr(mem_wr), .mem_be(mem_be), .mem_wdata(mem_wdata),
  .irq(irq), .stat_o(stat_o)
);

// File: tb/tb_rx_ring_engine.sv
`timescale 1ns/1ps
module tb_rx_ring_engine;

  localparam logic [27:0] RB = 28'h0ABCDE;
  localparam logic [31:0] SB = 32'h0123_4567;
  localparam logic [35:0] RING_A = {RB, 8'h00};
  localparam logic [35:0] STAT_A = {SB, 4'h0};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic        us_tick = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_last = 1'b0;
  logic        in_ready;
  logic        mem_rd, mem_wr;
  logic [35:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        irq;
  logic [31:0] stat_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int closes = 0, irq_cnt = 0, exp_rd = 0, exp_off = 0, last_fill = 0;
  int ic, c0, n, idx_exp;
  byte unsigned exp_q[$];

  rx_ring_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .us_tick(us_tick), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq), .stat_o(stat_o)
  );

  always #2 clk = ~clk;

  function automatic logic [31:0] desc_word(input logic [35:0] a);
    logic [35:0] i;
    i = (a - RING_A) >> 2;
    return {4'hA, 28'h0010000 + i[27:0] * 28'h40};
  endfunction

  function automatic logic [35:0] buf_base(input int idx);
    return 36'h001000000 + 36'(idx) * 36'h4000;
  endfunction

  function automatic logic [31:0] mk_cfg(input logic [1:0] md, input logic [3:0] lgv,
                                         input logic [1:0] bs, input logic [1:0] it,
                                         input logic [7:0] tmo);
    return {md, 6'd0, lgv, 2'd0, bs, 2'd0, it, tmo, 4'd0};
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic wreg(input logic [1:0] s, input logic [31:0] d);
    reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic put(input logic [7:0] b, input logic l);
    in_valid = 1'b1; in_data = b; in_last = l;
    while (!in_ready) @(negedge clk);
    exp_q.push_back(b);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic wait_n(input int k);
    repeat (k) @(negedge clk);
  endtask

  always @(posedge clk) if (mem_rd) mem_rdata <= desc_word(mem_addr);

  always @(negedge clk) begin
    logic [35:0] ea;
    byte unsigned eb;
    if (rst_n) begin
      if (irq) irq_cnt++;
      if (mem_rd)
        chk(mem_addr == RING_A + 36'(exp_rd * 4), "R2 fetch address", mem_addr, RING_A + 36'(exp_rd * 4));
      if (mem_wr && mem_be == 4'hF) begin
        chk(mem_addr == STAT_A, "R6 status address", mem_addr, STAT_A);
        chk(mem_wdata == 32'(exp_rd), "R6 status index", mem_wdata, exp_rd);
        last_fill = exp_off;
        exp_off = 0;
        exp_rd = (exp_rd + 1) & 31;
        closes++;
      end else if (mem_wr) begin
        ea = buf_base(exp_rd) + 36'(exp_off);
        eb = (exp_q.size() != 0) ? exp_q.pop_front() : 8'h00;
        chk(mem_addr == ea, "R3 data address", mem_addr, ea);
        chk(mem_be == (4'b0001 << ea[1:0]), "R3 byte lane", mem_be, 4'b0001 << ea[1:0]);
        chk(mem_wdata == {4{eb}}, "R3 data byte", mem_wdata, {4{eb}});
        exp_off++;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
      finish_up();
    end
  end

  initial begin
    void'($urandom(32'd4242));
    wait_n(4);
    rst_n = 1'b1;
    wait_n(1);
    // R1 reset state
    chk(in_ready == 1'b0, "R1 in_ready", in_ready, 0);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(!mem_wr && !mem_rd, "R1 memory quiet", {mem_wr, mem_rd}, 0);
    chk(stat_o == 32'h0100_0000, "R1 status", stat_o, 32'h0100_0000);

    // Setup: 32-entry ring, 4K buffers, irq to host, timeout 32 ticks
    wreg(2'd1, 32'(RB));
    wreg(2'd2, SB);
    wreg(2'd3, 32'h0000_000F);
    wreg(2'd0, mk_cfg(2'b10, 4'd5, 2'b00, 2'b01, 8'd1));

    for (int i = 0; i < 10; i++) put(8'($urandom), i == 9);
    wait_n(60);
    chk(closes == 1, "R5 timeout close", closes, 1);
    chk(last_fill == 10, "R5 partial fill", last_fill, 10);
    chk(irq_cnt == 1, "R7 irq on close", irq_cnt, 1);
    chk(stat_o[11:0] == 12'd0, "R6 stat index", stat_o[11:0], 0);

    // R5 restart on each byte: gaps under the limit
    for (int i = 0; i < 6; i++) begin
      put(8'($urandom), i == 5);
      if (i < 5) wait_n(20);
    end
    wait_n(10);
    chk(closes == 1, "R5 held open by bytes", closes, 1);
    wait_n(60);
    chk(closes == 2, "R5 close after gap", closes, 2);
    chk(last_fill == 6, "R5 fill count", last_fill, 6);

    // R4 full buffer spills into next descriptor
    for (int i = 0; i < 4099; i++) put(8'($urandom), i == 4098);
    wait_n(5);
    chk(closes == 3, "R4 full close", closes, 3);
    chk(last_fill == 4096, "R4 full size", last_fill, 4096);
    wait_n(60);
    chk(closes == 4, "R4 spill closed", closes, 4);
    chk(last_fill == 3, "R4 spill size", last_fill, 3);

    // R8 ring full at effective write index 8 (0x0F written)
    for (int k = 0; k < 4; k++) begin
      put(8'($urandom), 1'b1);
      wait_n(60);
    end
    chk(closes == 8, "R8 closes before full", closes, 8);
    wait_n(3);
    chk(in_ready == 1'b0, "R8 ring full holds off", in_ready, 0);
    chk(stat_o[24] == 1'b0, "R8 not idle while starved", stat_o[24], 0);
    wreg(2'd3, 32'h0000_0013);
    wait_n(6);
    chk(in_ready == 1'b1, "R8 resumes", in_ready, 1);

    // R7 no irq when target is 00
    wreg(2'd0, mk_cfg(2'b10, 4'd5, 2'b00, 2'b00, 8'd1));
    ic = irq_cnt;
    put(8'($urandom), 1'b1);
    wait_n(60);
    chk(closes == 9, "R7 close without irq", closes, 9);
    chk(irq_cnt == ic, "R7 irq suppressed", irq_cnt, ic);

    // R5 zero disables timeout
    wreg(2'd0, mk_cfg(2'b10, 4'd5, 2'b00, 2'b01, 8'd0));
    put(8'($urandom), 1'b0);
    put(8'($urandom), 1'b1);
    wait_n(300);
    chk(closes == 9, "R5 zero timeout never closes", closes, 9);
    wreg(2'd0, mk_cfg(2'b10, 4'd5, 2'b00, 2'b01, 8'd1));
    wait_n(5);
    chk(closes == 10, "R5 late enable closes", closes, 10);

    // R10 stop at frame boundary
    for (int i = 0; i < 3; i++) put(8'($urandom), 1'b0);
    wreg(2'd0, mk_cfg(2'b01, 4'd5, 2'b00, 2'b01, 8'd1));
    chk(stat_o[24] == 1'b0, "R10 busy mid-frame", stat_o[24], 0);
    put(8'($urandom), 1'b0);
    put(8'($urandom), 1'b1);
    wait_n(5);
    chk(closes == 11, "R10 frame closed", closes, 11);
    chk(last_fill == 5, "R10 whole frame kept", last_fill, 5);
    chk(stat_o[24] == 1'b1, "R10 idle after frame", stat_o[24], 1);
    in_valid = 1'b1;
    wait_n(5);
    chk(in_ready == 1'b0, "R10 new frame refused", in_ready, 0);
    in_valid = 1'b0;

    // R9 immediate stop with partial buffer
    wreg(2'd0, mk_cfg(2'b10, 4'd5, 2'b00, 2'b01, 8'd1));
    for (int i = 0; i < 4; i++) put(8'($urandom), 1'b0);
    wreg(2'd0, mk_cfg(2'b00, 4'd5, 2'b00, 2'b01, 8'd1));
    wait_n(5);
    chk(closes == 12, "R9 partial closed", closes, 12);
    chk(last_fill == 4, "R9 partial size", last_fill, 4);
    chk(stat_o[24] == 1'b1, "R9 idle", stat_o[24], 1);
    chk(in_ready == 1'b0, "R9 not ready", in_ready, 0);

    // R9 empty fetched buffer is given back
    wreg(2'd0, mk_cfg(2'b10, 4'd5, 2'b00, 2'b01, 8'd1));
    wait_n(6);
    chk(stat_o[24] == 1'b0, "R9 running again", stat_o[24], 0);
    wreg(2'd0, mk_cfg(2'b00, 4'd5, 2'b00, 2'b01, 8'd1));
    wait_n(6);
    chk(closes == 12, "R9 empty not reported", closes, 12);
    chk(stat_o[24] == 1'b1, "R9 idle after release", stat_o[24], 1);
    chk(stat_o[11:0] == 12'd11, "R9 last index kept", stat_o[11:0], 11);

    // R11 random traffic, ring wrap, clamped size field
    c0 = closes;
    for (int it = 0; it < 40; it++) begin
      wreg(2'd3, 32'(((exp_rd + 16) & ~7) & 31));
      wreg(2'd0, mk_cfg(2'b10, ($urandom % 2) ? 4'd5 : 4'($urandom % 5), 2'b00, 2'b01, 8'd1));
      n = 1 + int'($urandom % 6);
      for (int j = 0; j < n; j++) put(8'($urandom), j == n - 1);
      wait_n(60);
      idx_exp = (12 + it) % 32;
      chk(closes == c0 + it + 1, "R11 close count", closes, c0 + it + 1);
      chk(stat_o[11:0] == 12'(idx_exp), "R11 wrap index", stat_o[11:0], idx_exp);
      chk(last_fill == n, "R5 random fill", last_fill, n);
    end

    finish_up();
  end

endmodule